// File: doc/BRIEF.md
# Countdown Timer Interrupt Source

This block is a down-counter that a processor loads with a single swap instruction. In one step the instruction writes a new count and receives the count that was held before the write. When the count is non-zero, it drops by one on every clock cycle. When it steps from one to zero, the block sends a single-cycle request to the interrupt controller, and that request is latched into the controller's pending register.

A count of zero means the timer is idle. Software can stop a running timer by swapping in zero, and that swap raises no request. The write strobe has no back-pressure: a strobe is taken on every cycle in which it is high. For that reason the port is a plain strobe and not a valid/ready pair. The old-value output is combinational, so the instruction can capture it in the same cycle as its strobe.

Top module: `timer_irq_src`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the held count reads 0 on `old_count` and every bit of `irq_lines` is 0.
- R2: When `wr_en` is high at a rising edge, the count after that edge equals `wr_data`. `old_count` continuously shows the count held at the start of the current cycle, so in a write cycle it returns the value before the write and before any decrement.
- R3: With no write, a non-zero count decreases by exactly one at each rising edge.
- R4: With no write, a zero count stays at zero. It never wraps, and it raises no request.
- R5: If a value N ≥ 1 is written at edge k and no further write follows, `irq_lines[TIMER_LINE]` is high for exactly the one cycle after edge k+N. Writing 1 therefore fires the request after the next edge.
- R6: A write takes priority over the decrement in the same cycle. A write in the cycle where the count is 1 cancels that expiry, so no request is raised for it.
- R7: Writing zero disables the timer, and that write never raises a request.
- R8: The request appears only on bit TIMER_LINE (default 0) of the IRQ_LINES-wide `irq_lines` vector. All other bits stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Swap strobe; loads `wr_data` at the edge |
| wr_data | input | CNT_W | New count to load |
| old_count | output | CNT_W | Count held before the current cycle's update |
| irq_lines | output | IRQ_LINES | Interrupt request lines; only TIMER_LINE is driven |

## Verification
The assertions assume only that `wr_en` and `wr_data` are stable and known at each rising edge. The bench meets this by changing inputs only on falling edges. The bench itself does not rely on any particular write pattern: it sweeps every load value of an 8-bit counter, lets each one expire, and then directly drives writes at the interesting counts, including zero, one, the expiry cycle and a reset during a countdown. The single-pulse property depends on the fact that two expiries can never fall on adjacent edges, because after an expiry the count needs at least one edge at the value one before it can expire again.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DEF_CNT_W      = 32;
  localparam int DEF_IRQ_LINES  = 32;
  localparam int DEF_TIMER_LINE = 0;

  function automatic logic [DEF_IRQ_LINES-1:0] line_bit(input int idx);
    logic [DEF_IRQ_LINES-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/timer_count_core.sv
module timer_count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         expire
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         running;

  assign running = (cnt_q != ZERO);

  always_comb begin
    cnt_d = cnt_q;
    if (load)         cnt_d = load_val;
    else if (running) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ZERO;
    else        cnt_q <= cnt_d;
  end

  assign count  = cnt_q;
  assign expire = (cnt_q == ONE) && !load;

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));
  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == ZERO) |=> (cnt_q == ZERO));
  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/timer_irq_route.sv
module timer_irq_route #(
  parameter int LINES = 32,
  parameter int LINE  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  output logic [LINES-1:0] irq_lines
);
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= fire;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i == LINE) begin : g_tmr
      assign irq_lines[i] = pulse_q;
    end else begin : g_idle
      assign irq_lines[i] = 1'b0;
    end
  end

  // R5
  one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lines[LINE] |=> !irq_lines[LINE]);
  // R8
  always_comb begin
    if (rst_n) begin
      single_line_chk: assert ($onehot0(irq_lines));
    end
  end
endmodule

// File: rtl/timer_irq_src.sv
module timer_irq_src #(
  parameter int CNT_W      = timer_pkg::DEF_CNT_W,
  parameter int IRQ_LINES  = timer_pkg::DEF_IRQ_LINES,
  parameter int TIMER_LINE = timer_pkg::DEF_TIMER_LINE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CNT_W-1:0]     wr_data,
  output logic [CNT_W-1:0]     old_count,
  output logic [IRQ_LINES-1:0] irq_lines
);
  logic expire;

  timer_count_core #(.W(CNT_W)) core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_en),
    .load_val (wr_data),
    .count    (old_count),
    .expire   (expire)
  );

  timer_irq_route #(.LINES(IRQ_LINES), .LINE(TIMER_LINE)) route_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (expire),
    .irq_lines (irq_lines)
  );

  // R5 / R6 / R7: a request needs a count of one with no write in the prior cycle
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lines[TIMER_LINE] |-> ($past(old_count) == CNT_W'(1) && !$past(wr_en)));
  // R6
  write_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !irq_lines[TIMER_LINE]);
endmodule

// File: tb/timer_irq_src_tb_top.sv
module timer_irq_src_tb_top;
  localparam int W  = 8;
  localparam int NL = 4;
  localparam int TL = 0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  old_count;
  logic [NL-1:0] irq_lines;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  timer_irq_src #(.CNT_W(W), .IRQ_LINES(NL), .TIMER_LINE(TL)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .old_count(old_count), .irq_lines(irq_lines)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic look(input string req, input int exp_cnt, input bit exp_irq);
    chk(req, int'(old_count), exp_cnt);
    chk({req, "/irq"}, int'(irq_lines[TL]), int'(exp_irq));
    chk("R8", int'(irq_lines & ~(NL'(1) << TL)), 0);
  endtask

  task automatic tick(input bit w, input int d);
    wr_en = w;
    wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    look("R1", 0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look("R1", 0, 1'b0);

    // R2 R3 R4 R5: sweep every load value
    for (int n = 0; n < (1 << W); n++) begin
      look("R4", 0, 1'b0);
      tick(1'b1, n);
      look("R2", n, 1'b0);
      for (int j = 1; j <= n + 1; j++) begin
        tick(1'b0, 0);
        look("R3", (j <= n) ? n - j : 0, (n != 0) && (j == n));
      end
    end

    // R2: rewrite while running returns current count
    tick(1'b1, 5);
    tick(1'b0, 0);
    tick(1'b0, 0);
    look("R2", 3, 1'b0);
    tick(1'b1, 7);
    look("R2", 7, 1'b0);

    // R7: zero at the expiry cycle disables with no request
    tick(1'b1, 2);
    tick(1'b0, 0);
    look("R7", 1, 1'b0);
    tick(1'b1, 0);
    look("R7", 0, 1'b0);
    tick(1'b0, 0);
    look("R7", 0, 1'b0);

    // R6: write of 1 while count is 1 postpones expiry by a cycle
    tick(1'b1, 1);
    look("R6", 1, 1'b0);
    tick(1'b1, 1);
    look("R6", 1, 1'b0);
    tick(1'b0, 0);
    look("R6", 0, 1'b1);
    tick(1'b0, 0);
    look("R5", 0, 1'b0);

    // R1: reset in the middle of a countdown
    tick(1'b1, 9);
    tick(1'b0, 0);
    rst_n = 1'b0;
    #1;
    look("R1", 0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(1'b0, 0);
    look("R1", 0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule